// File: doc/BRIEF.md
# SDRAM Burst Write Engine

The engine moves a block of data into SDRAM when a single trigger pulse arrives. It asks an external arbiter for the memory bus. Once granted, it opens a row and streams fixed four-word write bursts across rising column addresses. Each burst starts directly after the previous one, with no idle cycles between them.

The engine leaves the write state in three cases: the block is finished, a refresh is pending at the end of a burst, or the open row has no columns left. It always leaves through a precharge. After the precharge wait it goes idle, asks the arbiter again, or opens the next row directly, depending on which exit was taken. Row and column progress is kept across a refresh detour, so writing resumes at the first column not yet written.

The block size, the row length, the ACTIVE-to-WRITE gap and the precharge gap are parameters. The write data comes from outside: the engine raises a strobe in each cycle in which it drives a word onto the data bus.

Top module: `sdram_burst_writer`

## Requirements
- R1: After reset the command bus carries NOP (cs_n, ras_n, cas_n, we_n = 0111), and `wr_req_o` and `flag_wr_o` are low.
- R2: In idle, `wr_trig_i` raises `flag_wr_o` and `wr_req_o` one cycle later, and `wr_req_o` stays high until the grant. A trigger while busy has no effect, and `wr_en_i` has no effect outside the request state.
- R3: The grant causes an ACTIVE command (0011) carrying the row on `sd_addr_o` and the bank on `sd_bank_o`. The first WRITE follows exactly T_RCD cycles later.
- R4: A WRITE command (0100) carries the column on the low address bits with address bit 10 low. `wr_data_rd_o` is high in the WRITE cycle and the 3 cycles after it, and in those cycles `sd_dq_o` equals `wr_data_i`.
- R5: Burst n of a row uses column 4·n. Bursts within a row are issued back to back, one WRITE every 4 cycles.
- R6: When the last burst of a row ends and the block is not finished, the engine precharges. If no refresh is pending, the next ACTIVE opens row+1 exactly T_RP cycles after the PRECHARGE, and writing restarts at column 0.
- R7: When `ref_req_i` is high during the last word of a burst that is not the final one, `flag_wr_end_o` pulses in that cycle. A PRECHARGE follows, then a new request, and after the grant writing resumes at the next unwritten column.
- R8: After XFER_BURSTS bursts the engine precharges, `flag_wr_o` falls, and the engine returns to idle without a new request. Completion takes priority over a pending refresh, which then raises no `flag_wr_end_o`.
- R9: PRECHARGE (0010) drives address bit 10 high (all banks). No ACTIVE comes sooner than T_RP cycles after a PRECHARGE.
- R10: Each new transfer starts at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_trig_i | input | 1 | Start of a block transfer |
| wr_en_i | input | 1 | Bus grant from the arbiter |
| ref_req_i | input | 1 | Refresh pending |
| wr_data_i | input | DQ_W | Write word from the data source |
| wr_req_o | output | 1 | Bus request to the arbiter |
| flag_wr_o | output | 1 | Transfer in progress |
| flag_wr_end_o | output | 1 | Burst finished and bus released for a refresh |
| wr_data_rd_o | output | 1 | Word taken from `wr_data_i` this cycle |
| sd_cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_bank_o | output | BANK_W | Bank address |
| sd_addr_o | output | ROW_W | Row, column or precharge address |
| sd_dq_o | output | DQ_W | Write data bus |

## Verification
The assertions assume the arbiter grants only while a request is open. They also assume that `ref_req_i` falls only once the engine has asked for the bus again or has finished, so a pending refresh is never lost mid-burst. The bench's arbiter model follows both rules: it grants a fixed delay after each rising request and clears the refresh flag when that request appears. The refresh flag is raised at chosen bursts: the first, one inside a row, the last of a row and the final one. These exercise each exit path and the priority among them.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ACT, S_WR, S_PRE} wr_state_e;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
endpackage

// File: rtl/sdw_timer.sv
module sdw_timer #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdw_addr.sv
module sdw_addr #(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 9,
  parameter int COLS        = 512,
  parameter int BURST       = 4,
  parameter int XFER_BURSTS = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             row_end_o,
  output logic             last_o
);
  localparam int XW = $clog2(XFER_BURSTS + 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - BURST);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [XW-1:0]    done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      done_q <= '0;
    end else if (clr_i) begin
      row_q  <= '0;
      col_q  <= '0;
      done_q <= '0;
    end else if (step_i) begin
      done_q <= done_q + 1'b1;
      if (row_end_o) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + COL_W'(BURST);
      end
    end
  end

  assign row_o     = row_q;
  assign col_o     = col_q;
  assign row_end_o = (col_q == COL_LAST);
  assign last_o    = (done_q == XW'(XFER_BURSTS - 1));

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && row_end_o) |=> (col_o == '0 && row_o == $past(row_o) + ROW_W'(1))); // R6
endmodule

// File: rtl/sdram_burst_writer.sv
module sdram_burst_writer
  import sdw_pkg::*;
#(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 9,   // must stay below 11 so bit 10 is free
  parameter int BANK_W      = 2,
  parameter int DQ_W        = 16,
  parameter int COLS        = 512,
  parameter int BURST       = 4,
  parameter int XFER_BURSTS = 256,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int BANK_ID     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_trig_i,
  input  logic              wr_en_i,
  input  logic              ref_req_i,
  input  logic [DQ_W-1:0]   wr_data_i,
  output logic              wr_req_o,
  output logic              flag_wr_o,
  output logic              flag_wr_end_o,
  output logic              wr_data_rd_o,
  output logic [3:0]        sd_cmd_o,
  output logic [BANK_W-1:0] sd_bank_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [DQ_W-1:0]   sd_dq_o
);
  localparam int BC_W = $clog2(BURST);
  localparam int TMAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TW   = $clog2(TMAX + 1);

  wr_state_e        st_q, st_d;
  logic             busy_q, fresh_q;
  logic [BC_W-1:0]  bc_q;
  logic             tmr_zero, burst_last, last_burst, row_end;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign burst_last = (st_q == S_WR) && (bc_q == BC_W'(BURST - 1));

  sdw_addr #(
    .ROW_W(ROW_W), .COL_W(COL_W), .COLS(COLS), .BURST(BURST), .XFER_BURSTS(XFER_BURSTS)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q == S_IDLE && wr_trig_i),
    .step_i   (burst_last),
    .row_o    (row),
    .col_o    (col),
    .row_end_o(row_end),
    .last_o   (last_burst)
  );

  sdw_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(st_d != st_q),
    .val_i ((st_d == S_ACT) ? TW'(T_RCD - 1) : TW'(T_RP - 1)),
    .zero_o(tmr_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (wr_trig_i) st_d = S_REQ;
      S_REQ:  if (wr_en_i)   st_d = S_ACT;
      S_ACT:  if (tmr_zero)  st_d = S_WR;
      S_WR:   if (burst_last && (last_burst || ref_req_i || row_end)) st_d = S_PRE;
      S_PRE:  if (tmr_zero) begin
                if (!busy_q)        st_d = S_IDLE;
                else if (ref_req_i) st_d = S_REQ;
                else                st_d = S_ACT;
              end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      busy_q  <= 1'b0;
      fresh_q <= 1'b0;
      bc_q    <= '0;
    end else begin
      st_q    <= st_d;
      fresh_q <= (st_d != st_q);
      bc_q    <= (st_q == S_WR) ? bc_q + 1'b1 : '0;
      if (st_q == S_IDLE && wr_trig_i)   busy_q <= 1'b1;
      else if (burst_last && last_burst) busy_q <= 1'b0;
    end
  end

  always_comb begin
    sd_cmd_o  = CMD_NOP;
    sd_addr_o = '0;
    if (st_q == S_ACT && fresh_q) begin
      sd_cmd_o  = CMD_ACT;
      sd_addr_o = row;
    end else if (st_q == S_WR && bc_q == '0) begin
      sd_cmd_o  = CMD_WR;
      sd_addr_o = ROW_W'(col);   // bit 10 low: no auto precharge
    end else if (st_q == S_PRE && fresh_q) begin
      sd_cmd_o      = CMD_PRE;
      sd_addr_o[10] = 1'b1;      // all banks
    end
  end

  assign wr_req_o      = (st_q == S_REQ);
  assign flag_wr_o     = busy_q;
  assign flag_wr_end_o = burst_last && !last_burst && ref_req_i;
  assign wr_data_rd_o  = (st_q == S_WR);
  assign sd_dq_o       = wr_data_rd_o ? wr_data_i : '0;
  assign sd_bank_o     = BANK_W'(BANK_ID);

  // cycles since last ACTIVE / PRECHARGE, saturating at the limit
  localparam int SA_W = $clog2(T_RCD + 1);
  localparam int SP_W = $clog2(T_RP + 1);
  logic [SA_W-1:0] since_act;
  logic [SP_W-1:0] since_pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '0;
      since_pre <= SP_W'(T_RP);
    end else begin
      if (sd_cmd_o == CMD_ACT)             since_act <= SA_W'(1);
      else if (since_act != SA_W'(T_RCD))  since_act <= since_act + 1'b1;
      if (sd_cmd_o == CMD_PRE)             since_pre <= SP_W'(1);
      else if (since_pre != SP_W'(T_RP))   since_pre <= since_pre + 1'b1;
    end
  end

  AST_RESET_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_wr_o) |-> (sd_cmd_o == CMD_NOP)); // R1
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> flag_wr_o); // R2
  AST_WRITE_AFTER_RCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_WR) |-> (since_act == SA_W'(T_RCD))); // R3
  AST_BEAT_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_WR) |=> wr_data_rd_o); // R4
  AST_END_THEN_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_end_o |=> (sd_cmd_o == CMD_PRE)); // R7
  AST_DONE_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_wr_o) |-> (sd_cmd_o == CMD_PRE)); // R8
  AST_PRE_ALL_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_PRE) |-> sd_addr_o[10]); // R9
  AST_ACT_AFTER_RP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_cmd_o == CMD_ACT) |-> (since_pre == SP_W'(T_RP))); // R9
endmodule

// File: tb/sim_sdram_burst_writer.sv
module sim_sdram_burst_writer;
  import sdw_pkg::*;

  localparam int ROW_W = 12, COL_W = 9, BANK_W = 2, DQ_W = 16;
  localparam int COLS = 16, BL = 4, XFER = 6, T_RCD = 2, T_RP = 3, BANK_ID = 1;
  localparam int BPR = COLS / BL;
  // ref_at, acts, pres, wr_end pulses, requests
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{-1, 2, 2, 0, 1},
    '{ 0, 3, 3, 1, 2},
    '{ 1, 3, 3, 1, 2},
    '{ 3, 2, 2, 1, 2},
    '{ 5, 2, 2, 0, 1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_trig_i = 1'b0, ref_req_i = 1'b0, gnt_en = 1'b0, idle_en = 1'b0;
  logic [DQ_W-1:0] wr_data_i = '0;
  logic wr_en_i;
  logic wr_req_o, flag_wr_o, flag_wr_end_o, wr_data_rd_o;
  logic [3:0] sd_cmd_o;
  logic [BANK_W-1:0] sd_bank_o;
  logic [ROW_W-1:0] sd_addr_o;
  logic [DQ_W-1:0] sd_dq_o;

  assign wr_en_i = gnt_en | idle_en;

  sdram_burst_writer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DQ_W(DQ_W), .COLS(COLS), .BURST(BL),
    .XFER_BURSTS(XFER), .T_RCD(T_RCD), .T_RP(T_RP), .BANK_ID(BANK_ID)
  ) u0 (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  int k = 0, cur_row = 0, last_act = 0, last_wr = -100, last_pre = -100;
  int n_act = 0, n_pre = 0, n_end = 0, n_req = 0, ref_at = -1, gnt_cnt = 0;
  bit wrote = 0, req_since_pre = 1, req_prev = 0, busy_prev = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // command monitor and arbiter model
  always @(negedge clk_i) if (rst_ni) begin
    cyc++;
    if (sd_cmd_o == CMD_ACT) begin
      n_act++;
      chk(int'(sd_addr_o) == k / BPR, "R6 R10 act row", int'(sd_addr_o), k / BPR);
      chk(sd_bank_o == BANK_W'(BANK_ID), "R3 bank", int'(sd_bank_o), BANK_ID);
      chk(cyc - last_pre >= T_RP, "R9 act gap", cyc - last_pre, T_RP);
      if (!req_since_pre) chk(cyc - last_pre == T_RP, "R6 direct reopen", cyc - last_pre, T_RP);
      cur_row = int'(sd_addr_o); last_act = cyc; wrote = 0;
    end
    if (sd_cmd_o == CMD_WR) begin
      chk(int'(sd_addr_o[COL_W-1:0]) == (k % BPR) * BL, "R5 R7 col", int'(sd_addr_o[COL_W-1:0]), (k % BPR) * BL);
      chk(sd_addr_o[10] == 1'b0, "R4 a10", int'(sd_addr_o[10]), 0);
      chk(cur_row == k / BPR, "R6 row", cur_row, k / BPR);
      if (!wrote) chk(cyc - last_act == T_RCD, "R3 rcd", cyc - last_act, T_RCD);
      else        chk(cyc - last_wr == BL, "R5 back to back", cyc - last_wr, BL);
      wrote = 1; last_wr = cyc; k++;
      if (k - 1 == ref_at) ref_req_i = 1'b1;
    end
    if (wrote || wr_data_rd_o) begin
      chk(wr_data_rd_o == (wrote && cyc - last_wr < BL), "R4 beat", int'(wr_data_rd_o), int'(wrote && cyc - last_wr < BL));
      if (wr_data_rd_o) chk(sd_dq_o == wr_data_i, "R4 dq", int'(sd_dq_o), int'(wr_data_i));
    end
    if (flag_wr_end_o) begin
      n_end++;
      chk(cyc - last_wr == BL - 1 && ref_req_i, "R7 end pulse", cyc - last_wr, BL - 1);
    end
    if (sd_cmd_o == CMD_PRE) begin
      n_pre++;
      chk(sd_addr_o[10] == 1'b1, "R9 a10", int'(sd_addr_o[10]), 1);
      last_pre = cyc; req_since_pre = 0; wrote = 0;
    end
    if (busy_prev && !flag_wr_o) chk(k == XFER, "R8 bursts at done", k, XFER);
    busy_prev = flag_wr_o;
    if (gnt_cnt > 0) begin
      gnt_cnt--;
      gnt_en = (gnt_cnt == 0);
    end else gnt_en = 1'b0;
    if (wr_req_o && !req_prev) begin
      n_req++; req_since_pre = 1; ref_req_i = 1'b0; gnt_cnt = 3;
    end
    req_prev = wr_req_o;
    wr_data_i = DQ_W'(cyc * 37 + 5);
  end

  task automatic run(input int r_at, input bit extra_trig, input int v);
    k = 0; n_act = 0; n_pre = 0; n_end = 0; n_req = 0;
    last_pre = -100; req_since_pre = 1; ref_at = r_at;
    @(negedge clk_i) wr_trig_i = 1'b1;
    @(negedge clk_i) wr_trig_i = 1'b0;
    chk(flag_wr_o && wr_req_o, "R2 trigger", int'(flag_wr_o), 1);
    if (extra_trig) begin
      repeat (10) @(negedge clk_i);
      wr_trig_i = 1'b1;
      @(negedge clk_i) wr_trig_i = 1'b0;
    end
    while (flag_wr_o) @(negedge clk_i);
    repeat (T_RP + 3) @(negedge clk_i);
    chk(!wr_req_o && sd_cmd_o == CMD_NOP, "R8 idle after done", int'(wr_req_o), 0);
    chk(k == XFER, "R8 write count", k, XFER);
    chk(n_act == VEC[v][1], "R6 R7 act count", n_act, VEC[v][1]);
    chk(n_pre == VEC[v][2], "R6 R7 pre count", n_pre, VEC[v][2]);
    chk(n_end == VEC[v][3], "R7 R8 end pulses", n_end, VEC[v][3]);
    chk(n_req == VEC[v][4], "R7 R8 requests", n_req, VEC[v][4]);
    ref_req_i = 1'b0; ref_at = -1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sd_cmd_o == CMD_NOP, "R1 reset cmd", int'(sd_cmd_o), int'(CMD_NOP));
    chk(!wr_req_o && !flag_wr_o, "R1 reset flags", int'(wr_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(sd_cmd_o == CMD_NOP && !flag_wr_o, "R1 idle after reset", int'(sd_cmd_o), int'(CMD_NOP));

    for (int v = 0; v < NV; v++) run(VEC[v][0], 1'b0, v);

    // grant outside request state is ignored
    @(negedge clk_i) idle_en = 1'b1;
    @(negedge clk_i) idle_en = 1'b0;
    repeat (T_RCD + 2) @(negedge clk_i);
    chk(n_act == VEC[NV-1][1] && !flag_wr_o && !wr_req_o, "R2 stray grant", n_act, VEC[NV-1][1]);

    // trigger while busy is ignored; restart again from row 0 col 0
    run(-1, 1'b1, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule